// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block turns one vector memory operation into a stream of per-element byte addresses, one per cycle. A start pulse captures the operation: a two-bit mode, a base scalar, a stride scalar, the vector length and the 64-bit element mask. The block then walks the elements in order from 0 upward. For each element it presents the address and an enable flag. The enable flag tells the memory side whether that element is really performed or only skipped by the mask. For indexed gather or scatter it drives an element number onto an index-vector read port and adds the returned offset to the base.

A fourth mode builds an index vector rather than addresses. For this mode the stream carries the offsets 0, R, 2R, ... 63R, where R is the stride scalar, and a register-file write stage stores them. The output stream is valid/ready. The block holds the address, enable and element number stable while `out_ready` is low and moves to the next element only on a cycle where valid and ready are both high. One cycle after the final element is accepted, `done` pulses for one cycle. The block ignores a start that arrives while an operation is still streaming.

Top module: `vec_agu`

## Requirements
- R1: Mode 2'b00 (unit stride): element i has address base + 8*i, for i = 0 .. VL-1.
- R2: Mode 2'b01 (strided): element i has address base + i*stride.
- R3: Mode 2'b10 (indexed): `idx_addr` equals the current element number, and the address is base + `idx_data`.
- R4: The stream carries exactly VL elements, numbered 0 .. VL-1 on `out_elem`. When VL is 0, no element is presented and `done` rises in the cycle after start.
- R5: `out_en` equals bit i of the captured mask for element i. With an all-ones mask, every element is enabled.
- R6: Mode 2'b11 (index creation): 64 elements carry the values i*stride, with `out_en` always 1. VL, mask and base have no effect in this mode.
- R7: While `out_valid` is high and `out_ready` is low, the address, enable and element number stay unchanged in the next cycle.
- R8: `done` is a one-cycle pulse in the cycle after the final element is accepted. `out_valid` is low while `done` is high.
- R9: A start pulse while an operation is streaming is ignored, and the running operation completes unchanged.
- R10: Address arithmetic wraps modulo 2^32.
- R11: After reset, `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts an operation; accepted only when idle |
| mode | input | 2 | 00 unit, 01 strided, 10 indexed, 11 index creation |
| base | input | 32 | Base address scalar |
| stride | input | 32 | Stride scalar (also the step for index creation) |
| vlen | input | 7 | Vector length, 0 to 64 |
| mask | input | 64 | Element mask, bit i for element i |
| idx_addr | output | 6 | Element number for the index-vector read port |
| idx_data | input | 32 | Offset read combinationally from the index vector |
| out_valid | output | 1 | Element address is valid |
| out_ready | input | 1 | Consumer accepts the element |
| out_addr | output | 32 | Element address or generated offset |
| out_en | output | 1 | Element is performed (mask bit) |
| out_elem | output | 6 | Element number |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle that the stream holds still under back-pressure and that unit-stride addresses step by 8 between accepted elements. They also check that the index port follows the element number, that `done` is a lone pulse with the stream idle, that the element number stays below the captured length, and that reset leaves the block idle. Only the bench's scenarios can show the full address sequences: strided, indexed and index-creation values, wrap-around past 2^32, mask patterns, the zero-length case, the precise cycle of `done`, and that a start during streaming changes nothing.

// File: rtl/vagu_pkg.sv
package vagu_pkg;
  typedef enum logic [1:0] {
    MODE_UNIT   = 2'b00,
    MODE_STRIDE = 2'b01,
    MODE_INDEX  = 2'b10,
    MODE_CREATE = 2'b11
  } vagu_mode_e;
endpackage

// File: rtl/vagu_ctrl.sv
module vagu_ctrl #(
  parameter int MAX_VL = 64,
  localparam int EW = $clog2(MAX_VL),
  localparam int CW = EW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          create,
  input  logic [CW-1:0] vlen,
  input  logic          ready,
  output logic          busy,
  output logic [EW-1:0] elem,
  output logic          load,
  output logic          accept,
  output logic          done
);
  logic [CW-1:0] n_eff, cnt_q;
  logic          last;

  always_comb begin
    if (create)                   n_eff = CW'(MAX_VL);
    else if (vlen > CW'(MAX_VL))  n_eff = CW'(MAX_VL);
    else                          n_eff = vlen;
  end

  assign load   = start && !busy;
  assign accept = busy && ready;
  assign last   = ({1'b0, elem} == (cnt_q - CW'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      elem  <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        elem  <= '0;
        cnt_q <= n_eff;
        if (n_eff == '0) done <= 1'b1;
        else             busy <= 1'b1;
      end else if (accept) begin
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          elem <= elem + EW'(1);
        end
      end
    end
  end

  // R8: done never lasts two cycles
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4: element number stays below captured length
  a_r4_elem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({1'b0, elem} < cnt_q));
  // R9: captured length is frozen while streaming
  a_r9_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(accept && last)) |=> $stable(cnt_q));
endmodule

// File: rtl/vagu_gen.sv
module vagu_gen
  import vagu_pkg::*;
#(
  parameter int AW         = 32,
  parameter int ELEM_BYTES = 8,
  parameter int MAX_VL     = 64,
  localparam int EW = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              accept,
  input  vagu_mode_e        mode_in,
  input  logic [AW-1:0]     base,
  input  logic [AW-1:0]     stride,
  input  logic [MAX_VL-1:0] mask,
  input  logic [EW-1:0]     elem,
  input  logic [AW-1:0]     idx_data,
  output logic [AW-1:0]     addr,
  output logic              en,
  output vagu_mode_e        mode_q
);
  logic [AW-1:0]     acc_q, step_q, base_q;
  logic [MAX_VL-1:0] mask_q;
  logic [AW-1:0]     step_sel;

  // step chosen per mode; unit stride uses the element size
  always_comb begin
    case (mode_in)
      MODE_UNIT: step_sel = AW'(ELEM_BYTES);
      default:   step_sel = stride;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      step_q <= '0;
      base_q <= '0;
      mask_q <= '0;
      mode_q <= MODE_UNIT;
    end else if (load) begin
      acc_q  <= (mode_in == MODE_CREATE) ? '0 : base;
      step_q <= step_sel;
      base_q <= base;
      mask_q <= mask;
      mode_q <= mode_in;
    end else if (accept) begin
      acc_q <= acc_q + step_q;
    end
  end

  always_comb begin
    addr = (mode_q == MODE_INDEX) ? (base_q + idx_data) : acc_q;
    en   = (mode_q == MODE_CREATE) ? 1'b1 : mask_q[elem];
  end
endmodule

// File: rtl/vec_agu.sv
module vec_agu
  import vagu_pkg::*;
#(
  parameter int AW         = 32,
  parameter int ELEM_BYTES = 8,
  parameter int MAX_VL     = 64,
  localparam int EW = $clog2(MAX_VL),
  localparam int CW = EW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [AW-1:0]     base,
  input  logic [AW-1:0]     stride,
  input  logic [CW-1:0]     vlen,
  input  logic [MAX_VL-1:0] mask,
  output logic [EW-1:0]     idx_addr,
  input  logic [AW-1:0]     idx_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [AW-1:0]     out_addr,
  output logic              out_en,
  output logic [EW-1:0]     out_elem,
  output logic              done
);
  vagu_mode_e    mode_e, mode_q;
  logic          busy, load, accept;
  logic [EW-1:0] elem;

  assign mode_e = vagu_mode_e'(mode);

  vagu_ctrl #(.MAX_VL(MAX_VL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .create(mode_e == MODE_CREATE), .vlen(vlen), .ready(out_ready),
    .busy(busy), .elem(elem), .load(load), .accept(accept), .done(done)
  );

  vagu_gen #(.AW(AW), .ELEM_BYTES(ELEM_BYTES), .MAX_VL(MAX_VL)) u_gen (
    .clk(clk), .rst_n(rst_n), .load(load), .accept(accept),
    .mode_in(mode_e), .base(base), .stride(stride), .mask(mask),
    .elem(elem), .idx_data(idx_data),
    .addr(out_addr), .en(out_en), .mode_q(mode_q)
  );

  assign out_valid = busy;
  assign out_elem  = elem;
  assign idx_addr  = elem;

  // R7: stream holds under back-pressure
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_elem) && $stable(out_en) &&
       (mode_q == MODE_INDEX || $stable(out_addr))));
  // R1: unit-stride addresses advance by the element size
  a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && mode_q == MODE_UNIT) |=>
      (!out_valid || out_addr == $past(out_addr) + AW'(ELEM_BYTES)));
  // R3: index port follows the streamed element
  a_r3_idx_port: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && mode_q == MODE_INDEX) |=>
      (!out_valid || idx_addr == $past(idx_addr) + EW'(1)));
  // R8: stream idle while done pulses
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);
  // R11: reset leaves the block idle
  a_r11_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !done));
endmodule

// File: tb/tb_vec_agu.sv
`timescale 1ns/1ps
module tb_vec_agu;
  localparam real TCK = 5.0;

  typedef struct packed {
    logic [31:0] addr;
    logic        en;
    logic [5:0]  elem;
  } item_t;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [31:0] base = '0, stride = '0;
  logic [6:0]  vlen = '0;
  logic [63:0] mask = '0;
  logic [5:0]  idx_addr, out_elem;
  logic [31:0] idx_data, out_addr;
  logic        out_valid, out_ready, out_en, done;

  logic [31:0] ivec [64];
  assign idx_data = ivec[idx_addr];

  vec_agu dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base(base),
    .stride(stride), .vlen(vlen), .mask(mask), .idx_addr(idx_addr),
    .idx_data(idx_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_en(out_en), .out_elem(out_elem), .done(done)
  );

  always #(TCK/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, last_acc_cyc = 0;
  string cur_req = "R0";
  item_t exp_q [$];
  logic rdy_rand = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // ready driver
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= rdy_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
  end
  initial out_ready = 1'b1;

  // monitor
  logic        hold_pend = 1'b0;
  item_t       hold_item;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (hold_pend) begin
        chk(out_valid && out_addr == hold_item.addr && out_en == hold_item.en
            && out_elem == hold_item.elem, "R7 hold",
            {out_addr, out_en, out_elem}, hold_item);
      end
      hold_pend = 1'b0;
      if (out_valid && !out_ready) begin
        hold_pend = 1'b1;
        hold_item = '{out_addr, out_en, out_elem};
      end
      if (out_valid && out_ready) begin
        last_acc_cyc = cyc;
        if (exp_q.size() == 0) begin
          chk(1'b0, {cur_req, " extra element"}, {out_addr, out_en, out_elem}, 0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk(out_addr == e.addr && out_en == e.en && out_elem == e.elem,
              cur_req, {out_addr, out_en, out_elem}, e);
        end
      end
    end
  end

  task automatic run_op(input logic [1:0] m, input logic [31:0] b, input logic [31:0] s,
                        input int vl, input logic [63:0] mk, input string req, input bit poke);
    int n;
    bit seen;
    n = (m == 2'b11) ? 64 : vl;
    cur_req = req;
    for (int i = 0; i < n; i++) begin
      item_t e;
      case (m)
        2'b00:   e.addr = b + 32'(i) * 32'd8;
        2'b01:   e.addr = b + 32'(i) * s;
        2'b10:   e.addr = b + ivec[i];
        default: e.addr = 32'(i) * s;
      endcase
      e.en   = (m == 2'b11) ? 1'b1 : mk[i];
      e.elem = 6'(i);
      exp_q.push_back(e);
    end
    @(posedge clk); #1;
    start = 1'b1; mode = m; base = b; stride = s; vlen = 7'(vl); mask = mk;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      @(posedge clk); #1;
      start = 1'b1; mode = 2'b01; base = 32'hDEAD_0000; stride = 32'd4;
      vlen = 7'd9; mask = '0;
      @(posedge clk); #1;
      start = 1'b0;
    end
    seen = 1'b0;
    for (int t = 0; t < 2000 && !seen; t++) begin
      @(negedge clk); #1;
      if (done) begin
        seen = 1'b1;
        if (n == 0) chk(t == 0, "R4 zero-length done timing", t, 0);
        else chk(cyc == last_acc_cyc + 1, "R8 done timing", cyc, last_acc_cyc + 1);
      end
    end
    chk(seen, {req, " R8 done seen"}, seen, 1);
    chk(exp_q.size() == 0, {req, " R4 element count"}, exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk); #1;
    chk(!done && !out_valid, "R8 done one cycle", {done, out_valid}, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) ivec[i] = 32'(i * 40 + 3) ^ 32'h0000_0100;
    #(TCK * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && !done, "R11 reset idle", {out_valid, done}, 0);
    #1 rst_n = 1'b1;

    run_op(2'b00, 32'h0000_1000, 32'd0, 5, '1, "R1 unit all-ones R5", 1'b0);
    rdy_rand = 1'b1;
    run_op(2'b00, 32'h0000_4000, 32'd0, 10, 64'h0000_0000_0000_0155, "R1 unit masked R5 R7", 1'b0);
    run_op(2'b01, 32'h0000_2000, 32'd24, 7, 64'hA5, "R2 strided R5", 1'b0);
    run_op(2'b10, 32'h0008_0000, 32'd0, 64, 64'hF0F0_1234_8001_7FFE, "R3 indexed full", 1'b0);
    run_op(2'b11, 32'h1234_5678, 32'd12, 3, 64'h0, "R6 create ignores vl/mask/base", 1'b0);
    run_op(2'b00, 32'h0000_1000, 32'd0, 0, '1, "R4 zero length", 1'b0);
    run_op(2'b00, 32'h0000_3000, 32'd0, 1, 64'h1, "R4 single element", 1'b0);
    run_op(2'b00, 32'hFFFF_FFF0, 32'd0, 4, '1, "R10 unit wrap", 1'b0);
    run_op(2'b01, 32'h0000_0010, 32'hFFFF_FFF8, 6, '1, "R10 negative stride wrap", 1'b0);
    run_op(2'b01, 32'h0000_5000, 32'd16, 12, '1, "R9 start while busy", 1'b1);
    rdy_rand = 1'b0;
    run_op(2'b10, 32'hFFFF_FF00, 32'd0, 8, 64'h3C, "R3 indexed wrap R10", 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule